// File: doc/BRIEF.md
# Auto-Negotiation Mode Resolver

This block sits behind a fast-link-pulse receiver in a 10/100 Ethernet physical layer. Each cycle with `cw_valid_i` high presents one decoded 16-bit link code word from the link partner. The block accepts a word only after it has been received the same way several times in a row, with the acknowledge bit left out of the comparison. It keeps the first accepted word as the partner ability register. After a second accepted run it resolves the operating mode from the local and partner technology abilities by a fixed priority. If the two sides have no ability in common, it raises a fault instead.

Two side flags report that the line carries plain 10BASE-T normal link pulses or 100BASE-TX idle. Either flag lets parallel detection select the link speed directly, with half duplex, and skip the code word exchange. A restart request or a link failure clears the block and starts a new negotiation. While the fiber mode input is high the block stays inactive.

Top module: `an_mode_resolver`

## Requirements
- R1: A code word counts as accepted only when `MATCH_N` (default 3) consecutive valid words are equal with bit 14 (acknowledge) masked. A differing word becomes the new candidate with a run length of one.
- R2: The first accepted word is stored in `partner_ability_o` with bit 14 cleared, one cycle after its last repeat. After that the register holds its value until negotiation restarts.
- R3: After a second accepted run, the common abilities `local_abil_i & partner_ability_o[8:5]` are resolved. The ability bits are 8 = 100 full, 7 = 100 half, 6 = 10 full and 5 = 10 half; `local_abil_i` bits 3..0 map onto 8..5. The priority is 100 full, 100 half, 10 full, 10 half. `done_o`, `speed100_o` and `full_duplex_o` reflect the result one cycle after the last word.
- R4: If the second run finds no common ability, `fault_o` rises, `done_o` stays low, and both speed and duplex read 0.
- R5: While negotiating, `idle100_det_i` gives 100 Mb/s half duplex if local bit 3 or 2 is set. Otherwise `nlp_det_i` gives 10 Mb/s half duplex if local bit 1 or 0 is set. When both flags are high, only the idle flag is considered. The result appears with `done_o` one cycle later and takes precedence over a word accepted in the same cycle.
- R6: A parallel detection at a speed the local side does not support leaves `done_o` low, and code word negotiation continues.
- R7: `restart_i` or `link_fail_i` clears `done_o`, `fault_o`, the speed, the duplex, the partner register and the match run. Negotiation then begins afresh.
- R8: While `fiber_mode_i` is high, code words and detect flags are ignored. `done_o` is low and `partner_ability_o` reads 0. When the input falls, negotiation starts afresh.
- R9: Cycles with `cw_valid_i` low neither count toward nor break a run.
- R10: Once a result is resolved, further words and detect flags leave all outputs unchanged until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; negotiation starts on release |
| restart_i | input | 1 | Explicit negotiation restart |
| link_fail_i | input | 1 | Link loss, restarts negotiation |
| fiber_mode_i | input | 1 | Bypass negotiation entirely |
| local_abil_i | input | 4 | Local technology abilities {100F,100H,10F,10H} |
| cw_valid_i | input | 1 | Code word strobe |
| cw_i | input | 16 | Decoded partner code word |
| nlp_det_i | input | 1 | 10BASE-T normal link pulses seen |
| idle100_det_i | input | 1 | 100BASE-TX idle seen |
| partner_ability_o | output | 16 | Stored partner ability word |
| speed100_o | output | 1 | Resolved speed: 1 = 100 Mb/s |
| full_duplex_o | output | 1 | Resolved duplex: 1 = full |
| done_o | output | 1 | Mode resolved |
| fault_o | output | 1 | No common ability |

## Verification
The bench sweeps every pairing of local and partner ability nibbles, and toggles the acknowledge bit between repeats. A design that compared the acknowledge bit would never accept a word, and a wrong priority shows up as the wrong speed or duplex for some pair. Runs broken by a differing word, and gaps of invalid cycles carrying a different word, go after the candidate reset. An off-by-one run length would accept a word early or late. Parallel detection is swept over all local abilities and flag mixes, to catch a design that grants an unsupported speed, reports full duplex, or stalls negotiation afterwards. Fiber mode, restarts and late traffic after a result show whether stale state leaks through.

// File: rtl/an_pkg.sv
package an_pkg;

   localparam int N_ABIL = 4;

   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_HUNT1 = 3'd1,
      ST_HUNT2 = 3'd2,
      ST_DONE  = 3'd3,
      ST_FAULT = 3'd4
   } an_state_e;

   typedef struct packed {
      logic speed100;
      logic full_dup;
   } an_mode_t;

endpackage

// File: rtl/an_run_detect.sv
module an_run_detect #(
   parameter int CW_W       = 16,
   parameter int ACK_BIT    = 14,
   parameter int MATCH_N    = 3,
   parameter bit IGNORE_ACK = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   input  logic            valid_i,
   input  logic [CW_W-1:0] word_i,
   output logic            confirm_o,
   output logic [CW_W-1:0] word_o
);

   localparam int CNT_W = $clog2(MATCH_N + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MATCH_N - 1);

   if (MATCH_N < 2) begin : g_bad_match
      $error("an_run_detect: MATCH_N must be at least 2");
   end
   if (ACK_BIT >= CW_W) begin : g_bad_ack
      $error("an_run_detect: ACK_BIT outside word");
   end

   logic [CW_W-1:0]  masked;
   logic [CW_W-1:0]  cand_q;
   logic [CNT_W-1:0] cnt_q;
   logic             hit;

   if (IGNORE_ACK) begin : g_mask_ack
      localparam logic [CW_W-1:0] ACK_MASK = CW_W'(1) << ACK_BIT;
      assign masked = word_i & ~ACK_MASK;
   end else begin : g_keep_ack
      assign masked = word_i;
   end

   assign hit       = (cnt_q != '0) && (masked == cand_q);
   assign confirm_o = valid_i && hit && (cnt_q == LAST_CNT);
   assign word_o    = masked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         cand_q <= '0;
      end else if (clear_i) begin
         cnt_q  <= '0;
      end else if (valid_i) begin
         if (confirm_o) begin
            cnt_q <= '0;
         end else if (hit) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end else begin
            cand_q <= masked;
            cnt_q  <= CNT_W'(1);
         end
      end
   end

   a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(MATCH_N));

   a_r1_new_candidate: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !clear_i && !hit) |=> (cnt_q == CNT_W'(1)));

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i && !clear_i) |=> ($stable(cnt_q) && $stable(cand_q)));

endmodule

// File: rtl/an_prio_resolve.sv
module an_prio_resolve
   import an_pkg::*;
(
   input  logic [N_ABIL-1:0] local_i,
   input  logic [N_ABIL-1:0] partner_i,
   output an_mode_t          mode_o,
   output logic              found_o
);

   logic [N_ABIL-1:0] common;
   logic [N_ABIL-1:0] pick;

   assign common = local_i & partner_i;

   for (genvar gi = 0; gi < N_ABIL; gi++) begin : g_pick
      if (gi == N_ABIL - 1) begin : g_top
         assign pick[gi] = common[gi];
      end else begin : g_lower
         assign pick[gi] = common[gi] & ~(|common[N_ABIL-1:gi+1]);
      end
   end

   assign found_o         = |pick;
   assign mode_o.speed100 = pick[3] | pick[2];
   assign mode_o.full_dup = pick[3] | pick[1];

   always_comb begin
      a_r3_pick_onehot: assert ($onehot0(pick));
   end

endmodule

// File: rtl/an_par_detect.sv
module an_par_detect
   import an_pkg::*;
(
   input  logic [N_ABIL-1:0] local_i,
   input  logic              nlp_i,
   input  logic              idle_i,
   output logic              hit_o,
   output logic              speed100_o
);

   logic sup100;
   logic sup10;

   assign sup100     = local_i[3] | local_i[2];
   assign sup10      = local_i[1] | local_i[0];
   assign speed100_o = idle_i;
   assign hit_o      = idle_i ? sup100 : (nlp_i & sup10);

   always_comb begin
      a_r6_needs_flag: assert (!hit_o || nlp_i || idle_i);
   end

endmodule

// File: rtl/an_mode_resolver.sv
module an_mode_resolver
   import an_pkg::*;
#(
   parameter int CW_W       = 16,
   parameter int ACK_BIT    = 14,
   parameter int ABIL_LSB   = 5,
   parameter int MATCH_N    = 3,
   parameter bit IGNORE_ACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              link_fail_i,
   input  logic              fiber_mode_i,
   input  logic [N_ABIL-1:0] local_abil_i,
   input  logic              cw_valid_i,
   input  logic [CW_W-1:0]   cw_i,
   input  logic              nlp_det_i,
   input  logic              idle100_det_i,
   output logic [CW_W-1:0]   partner_ability_o,
   output logic              speed100_o,
   output logic              full_duplex_o,
   output logic              done_o,
   output logic              fault_o
);

   if (ABIL_LSB + N_ABIL > CW_W) begin : g_bad_field
      $error("an_mode_resolver: ability field outside word");
   end
   if ((ACK_BIT >= ABIL_LSB) && (ACK_BIT < ABIL_LSB + N_ABIL)) begin : g_bad_overlap
      $error("an_mode_resolver: acknowledge bit inside ability field");
   end

   an_state_e       st_q;
   logic [CW_W-1:0] partner_q;
   an_mode_t        mode_q;

   logic            kill;
   logic            hunting;
   logic            run_clear;
   logic            confirm;
   logic [CW_W-1:0] conf_word;
   logic            pd_hit;
   logic            pd_speed;
   an_mode_t        res_mode;
   logic            res_found;

   assign kill      = restart_i | link_fail_i;
   assign hunting   = (st_q == ST_HUNT1) || (st_q == ST_HUNT2);
   assign run_clear = fiber_mode_i | kill | ~hunting | pd_hit;

   an_run_detect #(
      .CW_W       (CW_W),
      .ACK_BIT    (ACK_BIT),
      .MATCH_N    (MATCH_N),
      .IGNORE_ACK (IGNORE_ACK)
   ) i_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (run_clear),
      .valid_i   (cw_valid_i),
      .word_i    (cw_i),
      .confirm_o (confirm),
      .word_o    (conf_word)
   );

   an_prio_resolve i_prio (
      .local_i   (local_abil_i),
      .partner_i (partner_q[ABIL_LSB +: N_ABIL]),
      .mode_o    (res_mode),
      .found_o   (res_found)
   );

   an_par_detect i_pd (
      .local_i    (local_abil_i),
      .nlp_i      (nlp_det_i),
      .idle_i     (idle100_det_i),
      .hit_o      (pd_hit),
      .speed100_o (pd_speed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_HUNT1;
         partner_q <= '0;
         mode_q    <= '0;
      end else if (fiber_mode_i) begin
         st_q      <= ST_OFF;
         partner_q <= '0;
         mode_q    <= '0;
      end else if (kill) begin
         st_q      <= ST_HUNT1;
         partner_q <= '0;
         mode_q    <= '0;
      end else begin
         unique case (st_q)
            ST_OFF: st_q <= ST_HUNT1;
            ST_HUNT1, ST_HUNT2: begin
               if (pd_hit) begin
                  st_q            <= ST_DONE;
                  mode_q.speed100 <= pd_speed;
                  mode_q.full_dup <= 1'b0;
               end else if (confirm) begin
                  if (st_q == ST_HUNT1) begin
                     partner_q <= conf_word;
                     st_q      <= ST_HUNT2;
                  end else if (res_found) begin
                     mode_q <= res_mode;
                     st_q   <= ST_DONE;
                  end else begin
                     mode_q <= '0;
                     st_q   <= ST_FAULT;
                  end
               end
            end
            ST_DONE, ST_FAULT: st_q <= st_q;
            default: st_q <= ST_HUNT1;
         endcase
      end
   end

   assign partner_ability_o = partner_q;
   assign speed100_o        = mode_q.speed100;
   assign full_duplex_o     = mode_q.full_dup;
   assign done_o            = (st_q == ST_DONE);
   assign fault_o           = (st_q == ST_FAULT);

   a_r4_fault_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (!speed100_o && !full_duplex_o));

   a_r2_partner_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HUNT2 && !kill && !fiber_mode_i) |=> $stable(partner_q));

   a_r5_pd_half: assert property (@(posedge clk) disable iff (!rst_n)
      (hunting && pd_hit && !kill && !fiber_mode_i) |=> (done_o && !full_duplex_o));

   a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (kill && !fiber_mode_i) |=> (!done_o && !fault_o && partner_q == '0));

   a_r8_fiber_idle: assert property (@(posedge clk) disable iff (!rst_n)
      fiber_mode_i |=> (!done_o && !fault_o && partner_q == '0));

   a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !kill && !fiber_mode_i) |=> (done_o && $stable(mode_q)));

endmodule

// File: tb/test_an_mode_resolver.sv
`timescale 1ns/1ps
module test_an_mode_resolver;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        restart_i = 1'b0;
   logic        link_fail_i = 1'b0;
   logic        fiber_mode_i = 1'b0;
   logic [3:0]  local_abil_i = 4'h0;
   logic        cw_valid_i = 1'b0;
   logic [15:0] cw_i = 16'h0;
   logic        nlp_det_i = 1'b0;
   logic        idle100_det_i = 1'b0;
   logic [15:0] partner_ability_o;
   logic        speed100_o, full_duplex_o, done_o, fault_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   an_mode_resolver i_an_mode_resolver (
      .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .link_fail_i(link_fail_i),
      .fiber_mode_i(fiber_mode_i), .local_abil_i(local_abil_i),
      .cw_valid_i(cw_valid_i), .cw_i(cw_i), .nlp_det_i(nlp_det_i),
      .idle100_det_i(idle100_det_i), .partner_ability_o(partner_ability_o),
      .speed100_o(speed100_o), .full_duplex_o(full_duplex_o),
      .done_o(done_o), .fault_o(fault_o)
   );

   function automatic logic [15:0] mk(input logic [3:0] ab, input logic ack);
      return {1'b0, ack, 1'b0, 4'b0000, ab, 5'b00001};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] w);
      @(negedge clk);
      cw_valid_i = 1'b1;
      cw_i = w;
      @(negedge clk);
      cw_valid_i = 1'b0;
   endtask

   task automatic run3(input logic [3:0] ab);
      send(mk(ab, 1'b0));
      send(mk(ab, 1'b1));
      send(mk(ab, 1'b0));
   endtask

   task automatic kick;
      @(negedge clk);
      restart_i = 1'b1;
      @(negedge clk);
      restart_i = 1'b0;
   endtask

   task automatic outs(input string req, input logic d, input logic f,
                       input logic s, input logic fd);
      chk(req, {28'h0, d, f, s, fd}, {28'h0, d, f, s, fd} ^ {28'h0, done_o ^ d,
          fault_o ^ f, speed100_o ^ s, full_duplex_o ^ fd});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      outs("R7 reset outputs", 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R7 reset partner", {16'h0, partner_ability_o}, 32'h0);

      // R1 R2 R3 R4: full sweep of ability pairs, ack toggling
      for (int l = 0; l < 16; l++) begin
         for (int p = 0; p < 16; p++) begin
            logic [3:0] c;
            logic ed, ef, es, efd;
            local_abil_i = 4'(l);
            kick();
            send(mk(4'(p), 1'b1));
            send(mk(4'(p), 1'b0));
            chk("R1 no accept after two", {16'h0, partner_ability_o}, 32'h0);
            send(mk(4'(p), 1'b1));
            chk("R2 partner stored masked", {16'h0, partner_ability_o}, {16'h0, mk(4'(p), 1'b0)});
            chk("R3 not done after first run", {31'h0, done_o}, 32'h0);
            run3(4'(p));
            c = 4'(l) & 4'(p);
            ed = (c != 0); ef = (c == 0);
            es = c[3] | c[2];
            efd = c[3] | (!c[3] && !c[2] && c[1]);
            if (c == 0) outs("R4 no common ability fault", 1'b0, 1'b1, 1'b0, 1'b0);
            else        outs("R3 priority resolution", ed, ef, es, efd);
         end
      end

      // R1: mismatch restarts candidate
      local_abil_i = 4'hF;
      kick();
      send(mk(4'h3, 1'b0));
      send(mk(4'h3, 1'b0));
      send(mk(4'h8, 1'b0));
      chk("R1 broken run not accepted", {16'h0, partner_ability_o}, 32'h0);
      send(mk(4'h8, 1'b1));
      chk("R1 new candidate run of two", {16'h0, partner_ability_o}, 32'h0);
      send(mk(4'h8, 1'b0));
      chk("R1 new candidate accepted", {16'h0, partner_ability_o}, {16'h0, mk(4'h8, 1'b0)});

      // R9: invalid cycles carrying other words do not break a run
      kick();
      send(mk(4'h4, 1'b0));
      @(negedge clk); cw_i = mk(4'h1, 1'b0);
      @(negedge clk); @(negedge clk);
      send(mk(4'h4, 1'b0));
      cw_i = mk(4'h2, 1'b0);
      repeat (3) @(negedge clk);
      send(mk(4'h4, 1'b1));
      chk("R9 gaps ignored", {16'h0, partner_ability_o}, {16'h0, mk(4'h4, 1'b0)});
      run3(4'h4);
      outs("R9 resolved after gaps", 1'b1, 1'b0, 1'b1, 1'b0);

      // R10: traffic after result ignored
      run3(4'h1);
      run3(4'h1);
      @(negedge clk); nlp_det_i = 1'b1; idle100_det_i = 1'b1;
      @(negedge clk); nlp_det_i = 1'b0; idle100_det_i = 1'b0;
      outs("R10 result stable", 1'b1, 1'b0, 1'b1, 1'b0);
      chk("R10 partner stable", {16'h0, partner_ability_o}, {16'h0, mk(4'h4, 1'b0)});

      // R7: link failure clears
      @(negedge clk); link_fail_i = 1'b1;
      @(negedge clk); link_fail_i = 1'b0;
      outs("R7 link fail clears", 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R7 link fail partner", {16'h0, partner_ability_o}, 32'h0);
      run3(4'h2);
      run3(4'h2);
      outs("R7 renegotiates", 1'b1, 1'b0, 1'b0, 1'b1);

      // R8: fiber bypass
      @(negedge clk); fiber_mode_i = 1'b1;
      run3(4'hF);
      run3(4'hF);
      @(negedge clk); idle100_det_i = 1'b1;
      @(negedge clk); idle100_det_i = 1'b0;
      outs("R8 fiber no result", 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R8 fiber partner zero", {16'h0, partner_ability_o}, 32'h0);
      @(negedge clk); fiber_mode_i = 1'b0;
      @(negedge clk);
      run3(4'hF);
      run3(4'hF);
      outs("R8 after fiber negotiates", 1'b1, 1'b0, 1'b1, 1'b1);

      // R5 R6: parallel detection sweep
      for (int l = 0; l < 16; l++) begin
         for (int m = 1; m < 4; m++) begin
            logic sup, es;
            logic [3:0] lv;
            lv = 4'(l);
            local_abil_i = lv;
            kick();
            @(negedge clk);
            nlp_det_i = m[0]; idle100_det_i = m[1];
            @(negedge clk);
            nlp_det_i = 1'b0; idle100_det_i = 1'b0;
            es  = m[1];
            sup = m[1] ? (lv[3] | lv[2]) : (lv[1] | lv[0]);
            if (sup) begin
               outs("R5 parallel detect half duplex", 1'b1, 1'b0, es, 1'b0);
            end else begin
               outs("R6 unsupported detect no done", 1'b0, 1'b0, 1'b0, 1'b0);
               run3(4'hF);
               run3(4'hF);
               chk("R6 negotiation continues", {31'h0, done_o | fault_o}, 32'h1);
            end
         end
      end

      // R5: detection wins over same-cycle acceptance
      local_abil_i = 4'hF;
      kick();
      run3(4'h5);
      send(mk(4'h5, 1'b0));
      send(mk(4'h5, 1'b0));
      @(negedge clk);
      cw_valid_i = 1'b1; cw_i = mk(4'h5, 1'b0); nlp_det_i = 1'b1;
      @(negedge clk);
      cw_valid_i = 1'b0; nlp_det_i = 1'b0;
      outs("R5 detect beats acceptance", 1'b1, 1'b0, 1'b0, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule